// File: doc/BRIEF.md
# Neural Classifier Job Sequencer

This block is the control unit of a parallel neural-network classifier. One recognition job runs from start to finish under its control. After a start request it first takes in a fixed-length run of activation-table words and then a fixed-length run of weight words. Next comes a single configuration word giving the sub-network count, the hidden-neuron count and the image length. The image words follow. The sequencer counts every word and gives each an address and a target select. The datapath and the arithmetic engines sit outside this block.

Once the image is loaded, the sequencer runs one pass of the compute engines. It steps the bias addresses, then issues four engine operations in turn: hidden-layer sums, hidden activation, output-layer sums and output activation. Each operation is a one-cycle start pulse, and the sequencer then waits until every engine in use reports done. After that it asks an external maximum unit to fold in the pass's outputs. While sub-networks remain, it starts another pass on the next group of engines. When none remain, it presents the final result code for one cycle and returns to idle.

Top module: `nn_job_sequencer`

## Requirements
- R1: A job starts only when `job_start` is seen while `busy` is low. During a job `busy` stays high and `job_start` is ignored. While idle, `in_valid` produces no `load_we`.
- R2: Words with `in_valid` high are taken in this fixed order. First `SIG_WORDS` activation words with `load_sel`=0, then `WGT_WORDS` weight words with `load_sel`=1, then one configuration word with no `load_we`, then the image words with `load_sel`=2. Within each run `load_addr` counts 0,1,2,… on the strobes, and cycles without `in_valid` do not advance it.
- R3: The configuration word packs three fields. Bits [4:0] hold the sub-network count, bits [8:5] the hidden-neuron count and bits [15:9] the image word count. A count of zero for sub-networks or image words behaves as one.
- R4: At the start of every pass, `bias_we` is high for hidden+1 consecutive cycles while `bias_addr` steps 0..hidden.
- R5: Each pass issues four one-cycle `eng_start` pulses, with `eng_op` equal to 0 (hidden sums), 1 (hidden activation), 2 (output sums) and 3 (output activation), in that order.
- R6: After each `eng_start` the sequencer waits until `eng_done` is high for every engine set in `eng_active`. Done flags of inactive engines are ignored.
- R7: `eng_active` sets the low min(remaining, `ENGINES`) bits as a contiguous run. `pass_base` gives the index of the first sub-network in the pass (0, `ENGINES`, 2·`ENGINES`, …).
- R8: After the output activation, a one-cycle `max_start` is issued. `max_restart` is high with it only on the first pass of a job. The sequencer then waits for `max_done`.
- R9: A job runs ceil(sub-networks / `ENGINES`) passes, each going back to the bias phase.
- R10: After the final `max_done`, `result_valid` is high for exactly one cycle. `result_code` then equals `max_code` from that final `max_done`, and `busy` is low on the following cycle.
- R11: After reset the sequencer is idle with `busy`, `load_we`, `bias_we`, `eng_start`, `max_start` and `result_valid` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Request a new job (accepted when idle) |
| busy | output | 1 | High while a job is in progress |
| in_valid | input | 1 | A load word is present on `in_data` |
| in_data | input | 16 | Load word; decoded only in the configuration phase |
| load_we | output | 1 | Store strobe for the current load word |
| load_sel | output | 2 | Load target: 0 activation table, 1 weights, 2 image |
| load_addr | output | ADDR_W | Word address within the current load run |
| bias_we | output | 1 | Bias fetch strobe |
| bias_addr | output | ADDR_W | Bias index within the pass |
| eng_start | output | 1 | One-cycle start to the engines |
| eng_op | output | 2 | Engine operation code |
| eng_active | output | ENGINES | Engines taking part in the current pass |
| pass_base | output | 5 | First sub-network index of the pass |
| eng_done | input | ENGINES | Per-engine completion flags |
| max_start | output | 1 | One-cycle start to the maximum unit |
| max_restart | output | 1 | Maximum unit should discard its running best |
| max_done | input | 1 | Maximum unit finished this pass |
| max_code | input | 5 | Best-class code from the maximum unit |
| result_valid | output | 1 | One-cycle result strobe |
| result_code | output | 5 | Final classification code |

## Verification
Jobs are run with sub-network counts of 3, 10, 23, 31 and 0. A count of 3 gives a partial engine mask, 10 a full mask with a single pass, and 23 and 31 give three and four passes ending in short masks. These counts separate errors in the mask, the pass stepping and the running-best restart. Hidden counts 0, 2, 4, 10 and 15 check the length of the bias run. Image lengths of 0, 3 and 5 check the phase-length compare, including its zero case. Engines finish at staggered times and inactive engines never report done, so a sequencer that waits on the wrong flags either moves on early or hangs. A stray `job_start` in the middle of a job, and load words sent while idle, check that these inputs are ignored.

// File: rtl/nn_job_sequencer.sv
module nn_job_sequencer #(
  parameter int ENGINES   = 10,
  parameter int SUB_W     = 5,
  parameter int HID_W     = 4,
  parameter int IMG_W     = 7,
  parameter int ADDR_W    = 11,
  parameter int SIG_WORDS = 1024,
  parameter int WGT_WORDS = 1024,
  parameter int CODE_W    = 5,
  localparam int DATA_W   = SUB_W + HID_W + IMG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               job_start,
  output logic               busy,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  in_data,
  output logic               load_we,
  output logic [1:0]         load_sel,
  output logic [ADDR_W-1:0]  load_addr,
  output logic               bias_we,
  output logic [ADDR_W-1:0]  bias_addr,
  output logic               eng_start,
  output logic [1:0]         eng_op,
  output logic [ENGINES-1:0] eng_active,
  output logic [SUB_W-1:0]   pass_base,
  input  logic [ENGINES-1:0] eng_done,
  output logic               max_start,
  output logic               max_restart,
  input  logic               max_done,
  input  logic [CODE_W-1:0]  max_code,
  output logic               result_valid,
  output logic [CODE_W-1:0]  result_code
);

  typedef enum logic [4:0] {
    S_IDLE, S_SIG, S_WGT, S_DESC, S_IMG, S_BIAS,
    S_HS_GO, S_HS_W, S_HA_GO, S_HA_W, S_OS_GO, S_OS_W, S_OA_GO, S_OA_W,
    S_MX_GO, S_MX_W, S_SEND
  } st_t;

  localparam logic [ADDR_W:0] SIG_LEN = (ADDR_W+1)'(SIG_WORDS);
  localparam logic [ADDR_W:0] WGT_LEN = (ADDR_W+1)'(WGT_WORDS);
  localparam logic [SUB_W-1:0] ENG_N  = SUB_W'(ENGINES);

  st_t               state;
  logic [ADDR_W-1:0] cnt;
  logic [HID_W-1:0]  hid_n;
  logic [IMG_W-1:0]  img_n;
  logic [SUB_W-1:0]  sub_left;
  logic [ADDR_W:0]   phase_len;
  logic              last, all_done, loading;

  always_comb begin
    case (state)
      S_SIG:   phase_len = SIG_LEN;
      S_WGT:   phase_len = WGT_LEN;
      S_IMG:   phase_len = (ADDR_W+1)'(img_n);
      S_BIAS:  phase_len = (ADDR_W+1)'(hid_n) + 1'b1;
      default: phase_len = 1;
    endcase
  end

  assign last     = ({1'b0, cnt} + 1'b1) >= phase_len;
  assign all_done = &(eng_done | ~eng_active);
  assign loading  = (state == S_SIG) || (state == S_WGT) || (state == S_IMG);

  for (genvar i = 0; i < ENGINES; i++) begin : g_act
    assign eng_active[i] = sub_left > SUB_W'(i);
  end

  assign busy         = state != S_IDLE;
  assign load_we      = loading && in_valid;
  assign load_sel     = (state == S_WGT) ? 2'd1 : (state == S_IMG) ? 2'd2 : 2'd0;
  assign load_addr    = cnt;
  assign bias_we      = state == S_BIAS;
  assign bias_addr    = cnt;
  assign eng_start    = (state == S_HS_GO) || (state == S_HA_GO) ||
                        (state == S_OS_GO) || (state == S_OA_GO);
  assign max_start    = state == S_MX_GO;
  assign max_restart  = max_start && (pass_base == '0);
  assign result_valid = state == S_SEND;

  always_comb begin
    case (state)
      S_HA_GO, S_HA_W: eng_op = 2'd1;
      S_OS_GO, S_OS_W: eng_op = 2'd2;
      S_OA_GO, S_OA_W: eng_op = 2'd3;
      default:         eng_op = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      hid_n       <= '0;
      img_n       <= '0;
      sub_left    <= '0;
      pass_base   <= '0;
      result_code <= '0;
    end else begin
      case (state)
        S_IDLE: if (job_start) begin
          state <= S_SIG;
          cnt   <= '0;
        end
        S_SIG, S_WGT, S_IMG: if (in_valid) begin
          if (last) begin
            cnt   <= '0;
            state <= (state == S_SIG) ? S_WGT : (state == S_WGT) ? S_DESC : S_BIAS;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DESC: if (in_valid) begin
          sub_left  <= (in_data[SUB_W-1:0] == '0) ? SUB_W'(1) : in_data[SUB_W-1:0];
          hid_n     <= in_data[SUB_W +: HID_W];
          img_n     <= in_data[SUB_W+HID_W +: IMG_W];
          pass_base <= '0;
          state     <= S_IMG;
        end
        S_BIAS: if (last) begin
          cnt   <= '0;
          state <= S_HS_GO;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_HS_GO: state <= S_HS_W;
        S_HS_W:  if (all_done) state <= S_HA_GO;
        S_HA_GO: state <= S_HA_W;
        S_HA_W:  if (all_done) state <= S_OS_GO;
        S_OS_GO: state <= S_OS_W;
        S_OS_W:  if (all_done) state <= S_OA_GO;
        S_OA_GO: state <= S_OA_W;
        S_OA_W:  if (all_done) state <= S_MX_GO;
        S_MX_GO: state <= S_MX_W;
        S_MX_W: if (max_done) begin
          result_code <= max_code;
          if (sub_left > ENG_N) begin
            sub_left  <= sub_left - ENG_N;
            pass_base <= pass_base + ENG_N;
            state     <= S_BIAS;
          end else begin
            state <= S_SEND;
          end
        end
        S_SEND:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nn_job_sequencer_chk.sv
module nn_job_sequencer_chk #(
  parameter int ENGINES = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               job_start,
  input logic               busy,
  input logic               load_we,
  input logic               bias_we,
  input logic               eng_start,
  input logic [ENGINES-1:0] eng_active,
  input logic               max_start,
  input logic               max_restart,
  input logic               result_valid
);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !job_start) |=> !busy);

  assert_load_in_job_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |-> busy);

  assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_we, bias_we, eng_start, max_start, result_valid}));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_mask_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_active[0]);

  assert_mask_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> ((eng_active & (eng_active + 1'b1)) == '0));

  assert_max_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    max_start |=> !max_start);

  assert_restart_with_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    max_restart |-> max_start);

  assert_result_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> (!result_valid && !busy));

endmodule

bind nn_job_sequencer nn_job_sequencer_chk #(.ENGINES(ENGINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .busy(busy),
  .load_we(load_we), .bias_we(bias_we), .eng_start(eng_start),
  .eng_active(eng_active), .max_start(max_start), .max_restart(max_restart),
  .result_valid(result_valid)
);

// File: tb/nn_job_sequencer_bench.sv
module nn_job_sequencer_bench;
  localparam int ENG  = 10;
  localparam int SIGW = 6;
  localparam int WGTW = 9;
  localparam int AW   = 11;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst_n, job_start, busy, in_valid, load_we, bias_we, eng_start;
  logic           max_start, max_restart, max_done, result_valid;
  logic [15:0]    in_data;
  logic [1:0]     load_sel, eng_op;
  logic [AW-1:0]  load_addr, bias_addr;
  logic [ENG-1:0] eng_active, eng_done;
  logic [4:0]     pass_base, max_code, result_code;

  nn_job_sequencer #(.ENGINES(ENG), .ADDR_W(AW), .SIG_WORDS(SIGW), .WGT_WORDS(WGTW))
  u_nn_job_sequencer (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .busy(busy),
    .in_valid(in_valid), .in_data(in_data), .load_we(load_we), .load_sel(load_sel),
    .load_addr(load_addr), .bias_we(bias_we), .bias_addr(bias_addr),
    .eng_start(eng_start), .eng_op(eng_op), .eng_active(eng_active),
    .pass_base(pass_base), .eng_done(eng_done), .max_start(max_start),
    .max_restart(max_restart), .max_done(max_done), .max_code(max_code),
    .result_valid(result_valid), .result_code(result_code)
  );

  typedef struct packed {
    logic [4:0] sub;
    logic [3:0] hid;
    logic [6:0] img;
    logic [4:0] base;
  } job_t;

  job_t q[$];
  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sub_eff(job_t j);
    return (j.sub == 0) ? 1 : int'(j.sub);
  endfunction
  function automatic int passes_of(job_t j);
    return (sub_eff(j) + ENG - 1) / ENG;
  endfunction

  // engine and maximum-unit models
  int etmr[ENG];
  logic [ENG-1:0] emask = '0;
  int mtmr = 0, mcount = 0;
  always @(negedge clk) begin
    if (max_done) max_done = 1'b0;
    if (eng_start || max_start)
      chk((eng_done & emask) == emask, "R6 all active engines done before next start",
          int'(eng_done & emask), int'(emask));
    if (eng_start) begin
      emask = eng_active;
      eng_done = '0;
      for (int i = 0; i < ENG; i++) etmr[i] = 2 + i;
    end else begin
      for (int i = 0; i < ENG; i++)
        if (etmr[i] > 0) begin
          etmr[i]--;
          if (etmr[i] == 0 && emask[i]) eng_done[i] = 1'b1;
        end
    end
    if (max_start) mtmr = 2;
    else if (mtmr > 0) begin
      mtmr--;
      if (mtmr == 0) begin
        max_done = 1'b1;
        max_code = q[0].base + 5'(mcount);
        mcount++;
      end
    end
    if (result_valid) mcount = 0;
  end

  // monitor / scoreboard
  int n_sig = 0, n_wgt = 0, n_img = 0, n_bias = 0, n_bp = 0, n_start = 0, n_max = 0;
  bit after_rv = 0;
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      if (after_rv) begin
        chk(!busy, "R10 idle after result", int'(busy), 0);
        after_rv = 0;
      end
      if (!busy && in_valid)
        chk(!load_we, "R1 no load strobe while idle", int'(load_we), 0);
      if (load_we) begin
        case (load_sel)
          2'd0: begin
            chk(load_addr == AW'(n_sig) && n_wgt == 0, "R2 activation word addr/order", int'(load_addr), n_sig);
            n_sig++;
          end
          2'd1: begin
            chk(load_addr == AW'(n_wgt) && n_sig == SIGW, "R2 weight word addr/order", int'(load_addr), n_wgt);
            n_wgt++;
          end
          default: begin
            chk(load_sel == 2'd2 && load_addr == AW'(n_img) && n_wgt == WGTW,
                "R2 image word sel/addr/order", int'(load_addr), n_img);
            n_img++;
          end
        endcase
      end
      if (bias_we) begin
        chk(bias_addr == AW'(n_bp), "R4 bias address step", int'(bias_addr), n_bp);
        n_bp++;
        n_bias++;
      end
      if (eng_start) begin
        int p, rem, k;
        logic [ENG-1:0] m;
        p   = n_start / 4;
        rem = sub_eff(q[0]) - p * ENG;
        k   = (rem > ENG) ? ENG : rem;
        m   = ENG'((1 << k) - 1);
        chk(eng_op == 2'(n_start % 4), "R5 operation order", int'(eng_op), n_start % 4);
        chk(eng_active == m, "R7 active engine mask", int'(eng_active), int'(m));
        chk(pass_base == 5'(p * ENG), "R7 pass base", int'(pass_base), p * ENG);
        if (n_start % 4 == 0)
          chk(n_bp == int'(q[0].hid) + 1, "R4 bias run length", n_bp, int'(q[0].hid) + 1);
        n_start++;
      end
      if (max_start) begin
        chk(n_start == 4 * (n_max + 1), "R8 max after output activation", n_start, 4 * (n_max + 1));
        chk(max_restart == (n_max == 0), "R8 restart only on first pass", int'(max_restart), int'(n_max == 0));
        n_max++;
        n_bp = 0;
      end
      if (result_valid) begin
        job_t j;
        int ps, ie;
        if (q.size() == 0) begin
          chk(0, "R10 unexpected result", 1, 0);
        end else begin
          j  = q.pop_front();
          ps = passes_of(j);
          ie = (j.img == 0) ? 1 : int'(j.img);
          chk(result_code == j.base + 5'(ps - 1), "R10 result code", int'(result_code), int'(j.base) + ps - 1);
          chk(n_img == ie, "R3 image word count", n_img, ie);
          chk(n_sig == SIGW && n_wgt == WGTW, "R2 fixed run lengths", n_sig + n_wgt, SIGW + WGTW);
          chk(n_max == ps, "R9 pass count", n_max, ps);
          chk(n_start == 4 * ps, "R5 starts per job", n_start, 4 * ps);
          chk(n_bias == ps * (int'(j.hid) + 1), "R4 bias total", n_bias, ps * (int'(j.hid) + 1));
        end
        n_sig = 0; n_wgt = 0; n_img = 0; n_bias = 0; n_bp = 0; n_start = 0; n_max = 0;
        after_rv = 1;
      end
    end
  end

  task automatic send_word(input logic [15:0] d, input logic js);
    in_valid  = 1'b1;
    in_data   = d;
    job_start = js;
    @(negedge clk);
    in_valid  = 1'b0;
    job_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_job(input int sub, input int hid, input int img, input int base);
    job_t j;
    int ie;
    j.sub = 5'(sub); j.hid = 4'(hid); j.img = 7'(img); j.base = 5'(base);
    q.push_back(j);
    ie = (img == 0) ? 1 : img;
    job_start = 1'b1;
    @(negedge clk);
    job_start = 1'b0;
    for (int i = 0; i < SIGW; i++) send_word(16'h00a0 + 16'(i), 1'b0);
    for (int i = 0; i < WGTW; i++) send_word(16'h0b00 + 16'(i), i == 2);
    send_word({j.img, j.hid, j.sub}, 1'b0);
    for (int i = 0; i < ie; i++) send_word(16'hc000 + 16'(i), 1'b0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; job_start = 1'b0; in_valid = 1'b0; in_data = '0;
    eng_done = '0; max_done = 1'b0; max_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!busy && !load_we && !bias_we && !eng_start && !max_start && !result_valid,
        "R11 reset state", int'(busy), 0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) send_word(16'hffff, 1'b0);
    chk(!busy, "R1 idle words start nothing", int'(busy), 0);
    run_job(3, 2, 5, 4);
    run_job(10, 10, 4, 1);
    run_job(23, 4, 3, 7);
    run_job(0, 0, 0, 12);
    run_job(31, 15, 2, 20);
    run_job(11, 3, 1, 2);
    chk(q.size() == 0, "R10 one result per job", q.size(), 0);
    finish_run();
  end
endmodule